// File: doc/BRIEF.md
# Bitslip Word-Alignment Training Controller

This block finds the word boundary of a 1:4 deserializer during link training. The far end transmits a repeating 4-bit training pattern. Only one of the four rotations of that pattern seen on the deserializer's parallel output is the correct word alignment. The controller runs on the deserializer's slow (parallel) clock. It compares each parallel word against the expected pattern. When the two differ, it asks the deserializer to shift its word boundary by one bit, using a one-cycle slip pulse. It then lets the realigned data settle before it compares again.

A start request begins a search. The search ends in one of two ways. If the expected pattern appears on two consecutive words, the controller raises a sticky lock flag. If all four alignments have been tried without a match, it raises a sticky failure flag and stops issuing slips. A further slip would only repeat an alignment that was already tried.

The parallel word is taken on every slow-clock cycle. A deserializer cannot be stalled, so the data input has no valid/ready handshake and no back-pressure. All pins are plain control, status or data levels.

Top module: `bitslip_align_ctrl`

## Requirements
- R1: After reset, bitslip, locked and failed are all low. They stay low, and no slip is issued, until a start request is sampled.
- R2: Every slip request is a bitslip pulse exactly one slow-clock cycle wide.
- R3: After each pulse, the controller waits a fixed 3 cycles before it resumes comparing. While the data stays misaligned, two pulses in one search are therefore separated by exactly 4 low cycles.
- R4: Lock is declared only after rx_word equals pattern on two consecutive sampled cycles. With stable data needing k slips (0 to 3), locked rises 5k+2 cycles after the edge that samples start.
- R5: A sampled rx_word that differs from pattern during comparison triggers a slip, unless 3 slips have already been issued in this search.
- R6: A search issues at most 3 pulses. If the fourth alignment also mismatches, failed rises 16 cycles after the start edge and stays high. Bitslip stays low while failed is high.
- R7: While locked, bitslip stays low and locked stays high whatever rx_word does, until reset or a new start.
- R8: A start request, in any state including mid-search, clears locked and failed at the next edge and restarts the search from the first comparison with a zero slip count.
- R9: locked and failed are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow (parallel) clock of the deserializer |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or restart an alignment search (level sampled each edge) |
| rx_word | input | 4 | Parallel word from the deserializer, taken every cycle |
| pattern | input | 4 | Expected training word in its correct alignment |
| bitslip | output | 1 | One-cycle request to shift the deserializer word boundary |
| locked | output | 1 | Sticky: correct alignment found |
| failed | output | 1 | Sticky: all four alignments tried without a match |

## Verification
Each result has a fixed cycle count, measured from the edge that samples start. The first comparison is on the next edge. Each slip costs five cycles: one to decide, one pulse cycle and three settling cycles. So locked is due at cycle 5k+2, and failed at cycle 16 after three slips. The bench's deserializer model applies each slip to the data three edges after the pulse. The bench samples every output at the falling edge of each cycle, and it compares locked and failed against those formulas in every cycle of the search, not only at the end. Pulse width, pulse spacing and pulse count are measured from the same falling-edge samples.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SLIP,
    ST_WAIT,
    ST_LOCKED,
    ST_FAIL
  } bsa_state_e;
endpackage

// File: rtl/bsa_match_run.sv
// Counts consecutive matching words while comparing is enabled.
module bsa_match_run #(
  parameter int RUN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic hit,
  output logic done
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] cnt;

  assign done = en && hit && (cnt == CW'(RUN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (clear || !en || !hit || done) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  generate
    if (RUN >= 2) begin : g_run_chk
      // R4: a lock decision needs a match in this cycle and the one before
      a_r4_two_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hit && $past(en && hit)));
    end
  endgenerate
endmodule

// File: rtl/bsa_settle.sv
// Settling timer, runs while the FSM waits after a slip.
module bsa_settle #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!run || expired) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bsa_slip_count.sv
// Slips issued in the current search.
module bsa_slip_count #(
  parameter int MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_max
);
  localparam int CW = $clog2(MAX + 1);
  logic [CW-1:0] cnt;

  assign at_max = (cnt == CW'(MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R6: never count past the bound
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !at_max);
endmodule

// File: rtl/bitslip_align_ctrl.sv
module bitslip_align_ctrl #(
  parameter int WORD_W     = 4,
  parameter int SETTLE_CYC = 3,
  parameter int MATCH_RUN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] pattern,
  output logic              bitslip,
  output logic              locked,
  output logic              failed
);
  import bsa_pkg::*;

  localparam int MAX_SLIPS = WORD_W - 1;
  localparam int GAP_MIN   = SETTLE_CYC + 1;
  localparam int GW        = $clog2(GAP_MIN + 1);

  bsa_state_e state, nxt;
  logic hit, run_done, settle_done, slips_max;

  assign hit = (rx_word == pattern);

  bsa_match_run #(.RUN(MATCH_RUN)) u_match (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .en(state == ST_CHECK), .hit(hit), .done(run_done)
  );

  bsa_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT && !start),
    .expired(settle_done)
  );

  bsa_slip_count #(.MAX(MAX_SLIPS)) u_slips (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .inc(state == ST_SLIP), .at_max(slips_max)
  );

  always_comb begin
    nxt = state;
    if (start) nxt = ST_CHECK;
    else begin
      unique case (state)
        ST_IDLE:   nxt = ST_IDLE;
        ST_CHECK: begin
          if (!hit) nxt = slips_max ? ST_FAIL : ST_SLIP;
          else if (run_done) nxt = ST_LOCKED;
        end
        ST_SLIP:   nxt = ST_WAIT;
        ST_WAIT:   if (settle_done) nxt = ST_CHECK;
        ST_LOCKED: nxt = ST_LOCKED;
        ST_FAIL:   nxt = ST_FAIL;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else state <= nxt;
  end

  assign bitslip = (state == ST_SLIP);
  assign locked  = (state == ST_LOCKED);
  assign failed  = (state == ST_FAIL);

  // Cycles since the last pulse of this search, saturating.
  logic [GW-1:0] since_slip;
  always_ff @(posedge clk) begin
    if (!rst_n || start) since_slip <= GW'(GAP_MIN);
    else if (bitslip) since_slip <= '0;
    else if (since_slip != GW'(GAP_MIN)) since_slip <= since_slip + 1'b1;
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bitslip |=> !bitslip);
  a_r3_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    bitslip |-> (since_slip == GW'(GAP_MIN)));
  a_r6_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    failed |-> !bitslip);
  a_r7_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !start) |=> (locked && !bitslip));
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!locked && !failed));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && failed));
endmodule

// File: tb/bitslip_align_ctrl_test.sv
module bitslip_align_ctrl_test;
  logic clk = 1'b0;
  logic rst_n, start, model_clr;
  logic [3:0] base, pattern, rx_word;
  logic [1:0] rot, pend;
  logic bitslip, locked, failed;
  int checks = 0, errors = 0;
  bit reported = 0;

  always #2 clk = ~clk;

  bitslip_align_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_word(rx_word),
    .pattern(pattern), .bitslip(bitslip), .locked(locked), .failed(failed)
  );

  function automatic logic [3:0] rotr(logic [3:0] v, int r);
    logic [7:0] d;
    d = {v, v} >> r;
    return d[3:0];
  endfunction

  function automatic int exp_slips(logic [3:0] b, logic [3:0] p);
    for (int r = 0; r < 4; r++) if (rotr(b, r) == p) return r;
    return 4;
  endfunction

  // Deserializer model: a slip shows on the word three edges after the pulse.
  assign rx_word = rotr(base, int'(rot));
  always @(posedge clk) begin
    if (model_clr) begin rot <= 2'd0; pend <= 2'd0; end
    else begin
      pend <= {pend[0], bitslip};
      if (pend[1]) rot <= rot + 2'd1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic run_trial(logic [3:0] b, logic [3:0] p);
    int k, pulses, bad_t, bad_n, bad_w, bad_g, bad_x, low_run, bad_h, exp_p;
    bit prev_bs, el, ef;
    k = exp_slips(b, p);
    pulses = 0; bad_t = 0; bad_n = -1; bad_w = 0; bad_g = 0; bad_x = 0;
    low_run = -1; prev_bs = 0; bad_h = 0;
    @(negedge clk);
    base = b; pattern = p; start = 1'b1; model_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; model_clr = 1'b0;
    chk(!locked && !failed, "R8", "flags after start", {locked, failed}, 0);
    for (int n = 1; n <= 22; n++) begin
      @(posedge clk);
      @(negedge clk);
      el = (k < 4) && (n >= 5 * k + 2);
      ef = (k == 4) && (n >= 16);
      if (locked !== el || failed !== ef) begin
        bad_t++;
        if (bad_n < 0) bad_n = n;
      end
      if (locked && failed) bad_x++;
      if (bitslip) begin
        if (prev_bs) bad_w++;
        else begin
          pulses++;
          if (low_run >= 0 && low_run != 4) bad_g++;
        end
        low_run = 0;
      end else if (low_run >= 0) low_run++;
      prev_bs = bitslip;
    end
    if (k < 4) chk(bad_t == 0, "R4", "lock timing, first bad cycle", bad_n, 5 * k + 2);
    else chk(bad_t == 0, "R6", "fail timing, first bad cycle", bad_n, 16);
    exp_p = (k < 4) ? k : 3;
    chk(pulses == exp_p, "R5", "slip pulse count", pulses, exp_p);
    chk(bad_w == 0, "R2", "wide pulses", bad_w, 0);
    chk(bad_g == 0, "R3", "pulse gaps not 4", bad_g, 0);
    chk(bad_x == 0, "R9", "both flags high", bad_x, 0);
    // Scramble the data: sticky flags must hold, no slips.
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (bitslip || locked !== (k < 4) || failed !== (k == 4)) bad_h++;
      base = 4'($urandom);
    end
    if (k < 4) chk(bad_h == 0, "R7", "lock hold under noise", bad_h, 0);
    else chk(bad_h == 0, "R6", "fail hold under noise", bad_h, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 1, 0);
    report();
    $finish;
  end

  initial begin
    int seed_init, quiet;
    logic [3:0] b, p;
    seed_init = $urandom(32'd9137);
    rst_n = 1'b0; start = 1'b0; model_clr = 1'b1;
    base = 4'b1000; pattern = 4'b0011;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bitslip && !locked && !failed, "R1", "outputs in reset",
        {bitslip, locked, failed}, 0);
    rst_n = 1'b1; model_clr = 1'b0;
    quiet = 0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (bitslip || locked || failed) quiet++;
    end
    chk(quiet == 0, "R1", "idle without start", quiet, 0);

    // Directed: every slip count, failure, symmetric and constant patterns.
    for (int k = 0; k < 4; k++) run_trial(4'b1000, rotr(4'b1000, k));
    run_trial(4'b1000, 4'b0011);
    run_trial(4'b0101, 4'b1010);
    run_trial(4'b0000, 4'b0000);
    run_trial(4'b1111, 4'b0111);

    // R8: restart in the middle of a failing search.
    @(negedge clk);
    base = 4'b1110; pattern = 4'b0000; start = 1'b1; model_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; model_clr = 1'b0;
    repeat (8) @(negedge clk);
    run_trial(4'b1100, rotr(4'b1100, 2));

    // Constrained random trials.
    for (int t = 0; t < 24; t++) begin
      b = 4'($urandom);
      p = ($urandom % 3 != 0) ? rotr(b, int'($urandom % 4)) : 4'($urandom);
      run_trial(b, p);
    end

    report();
    $finish;
  end
endmodule